// File: doc/BRIEF.md
# Write-Triggered Multiply-Accumulate Peripheral

This block is a register-mapped arithmetic helper for a small 16-bit processor. Software picks an operation and a data type in a control register, then writes operand registers. No start command exists. The unit counts operand writes and fires on the write that completes the operand set. The product is combined with a 48-bit accumulator in one of four ways: plain product, add, negate or subtract. Each way can write the accumulator back or leave it untouched.

A 32-bit result window can be read in the cycle after the triggering write. When the accumulator is written back, its three 16-bit words take one more cycle to change. A new operation may fire during that cycle, because the pending value is forwarded into the arithmetic. An overflow flag records carry, borrow or signed overflow of the accumulator arithmetic. A self-clearing bit in the control register wipes the unit back to its reset state.

Top module: `mac_periph`

## Requirements
- R1: Register map (3-bit address): 0 control, 1 operand A, 2 operand B, 3/4/5 accumulator bits 15:0/31:16/47:32 (read/write), 6/7 result window bits 15:0/31:16 (read-only). Control bits: [0] add/sub with accumulator, [1] negate/subtract, [2] hold accumulator, [3] unsigned data, [4] square mode, [5] clear (write-only, reads 0), [6] overflow flag (read-only). After reset every register reads 0.
- R2: With hold=0, add mode stores MC+P in the accumulator and shows the low 32 bits of MC+2·P in the window. Subtract mode stores MC−P and shows the low 32 bits of MC−2·P. P is the product, sign-extended when signed.
- R3: Code 000 stores P in the accumulator and shows P in the window. Code 010 stores −P and shows −P. For signed data both codes clear the overflow flag.
- R4: In two-operand mode the unit fires only on a write to the operand register other than the one already written. Writing the same register again reloads it without firing. Either register may be written first.
- R5: With hold=1 (codes 1xx) the accumulator keeps its value. The window shows P, −P, or the low 32 bits of MC±P.
- R6: The window holds the new result in the cycle after the triggering write. A written-back accumulator still reads its old value in that cycle and its new value one cycle later.
- R7: An operation fired while an accumulator update is still pending uses the pending value as MC.
- R8: Writing the control register with bit 5 set clears both operands, the accumulator, the window, the overflow flag and the operand-write count.
- R9: For add/subtract with hold=0, the overflow flag becomes 1 on signed overflow of the 48-bit result (signed data) or on carry/borrow out of bit 47 (unsigned data), and 0 otherwise.
- R10: Unsigned negate (code x10 with the unsigned bit set) is invalid and sets the overflow flag to 1.
- R11: In square mode a single write to operand A fires with P = A·A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Write address |
| wdata | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rdata | output | 16 | Read data (combinational) |

## Verification
The arithmetic is exercised with signed mixed-sign operands, full-scale unsigned operands, and a preloaded accumulator near the signed limit. These separate sign extension from zero extension and show whether the overflow flag is computed for the right data type. Accumulate and subtract runs compare the window against the accumulator, which exposes any mix-up between the doubled and single product. Write orderings cover B-before-A, a repeated A, a clear between operands, and a run of square-mode writes on consecutive cycles. The last of these shows whether the pending accumulator value is forwarded.

// File: rtl/mac_periph.sv
module mac_periph #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic [2:0]    rd_addr,
  output logic [DW-1:0] rdata
);
  localparam int PW = 2 * DW;
  localparam int AW = 3 * DW;

  logic [DW-1:0] ma, mb;
  logic [AW-1:0] mc, pend_val;
  logic          pend_v;
  logic [PW-1:0] res;
  logic [2:0]    op;
  logic          uns, sq, ovf, half, half_b;

  wire wr_c = wr_en && addr == 3'd0;
  wire wr_a = wr_en && addr == 3'd1;
  wire wr_b = wr_en && addr == 3'd2;
  wire clr  = wr_c && wdata[5];

  wire trig = sq ? wr_a : (half && ((wr_a && half_b) || (wr_b && !half_b)));

  wire [DW-1:0] opa = wr_a ? wdata : ma;
  wire [DW-1:0] opb = sq ? opa : (wr_b ? wdata : mb);
  wire          sgn = !uns;

  wire [PW-1:0] ax   = {{DW{sgn & opa[DW-1]}}, opa};
  wire [PW-1:0] bx   = {{DW{sgn & opb[DW-1]}}, opb};
  wire [PW-1:0] prod = ax * bx;
  wire [AW-1:0] pext = {{DW{sgn & prod[PW-1]}}, prod};

  wire accm = op[0];
  wire subt = op[1];
  wire hold = op[2];

  wire [AW-1:0] mc_eff = pend_v ? pend_val : mc;

  wire [AW:0] sum = subt ? ({1'b0, mc_eff} - {1'b0, pext})
                         : ({1'b0, mc_eff} + {1'b0, pext});
  wire s_ovf = subt ? ((mc_eff[AW-1] != pext[AW-1]) && (sum[AW-1] != mc_eff[AW-1]))
                    : ((mc_eff[AW-1] == pext[AW-1]) && (sum[AW-1] != mc_eff[AW-1]));
  wire acc_ovf = uns ? sum[AW] : s_ovf;

  wire [PW-1:0] addend  = hold ? prod : {prod[PW-2:0], 1'b0};
  wire [PW-1:0] win_acc = subt ? (mc_eff[PW-1:0] - addend) : (mc_eff[PW-1:0] + addend);
  wire [PW-1:0] win     = accm ? win_acc : (subt ? -prod : prod);
  wire [AW-1:0] mc_new  = accm ? sum[AW-1:0] : (subt ? -pext : pext);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ma <= '0; mb <= '0; mc <= '0; pend_val <= '0; pend_v <= 1'b0;
      res <= '0; op <= '0; uns <= 1'b0; sq <= 1'b0; ovf <= 1'b0;
      half <= 1'b0; half_b <= 1'b0;
    end else begin
      if (wr_c) begin
        op  <= wdata[2:0];
        uns <= wdata[3];
        sq  <= wdata[4];
      end
      if (clr) begin
        ma <= '0; mb <= '0; mc <= '0; pend_v <= 1'b0;
        res <= '0; ovf <= 1'b0; half <= 1'b0; half_b <= 1'b0;
      end else begin
        if (wr_a) ma <= wdata;
        if (wr_b) mb <= wdata;
        mc     <= mc_eff;
        pend_v <= 1'b0;
        for (int i = 0; i < 3; i++)
          if (wr_en && addr == 3'(3 + i)) mc[i*DW +: DW] <= wdata;
        if (trig) begin
          res  <= win;
          half <= 1'b0;
          if (!hold) begin
            pend_v   <= 1'b1;
            pend_val <= mc_new;
          end
          if (subt && !accm && uns) ovf <= 1'b1;
          else if (!hold)           ovf <= accm ? acc_ovf : 1'b0;
        end else if (wr_a && !sq) begin
          half <= 1'b1; half_b <= 1'b0;
        end else if (wr_b && !sq) begin
          half <= 1'b1; half_b <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0:    rdata = {{(DW-7){1'b0}}, ovf, 1'b0, sq, uns, op};
      3'd1:    rdata = ma;
      3'd2:    rdata = mb;
      3'd3:    rdata = mc[DW-1:0];
      3'd4:    rdata = mc[2*DW-1:DW];
      3'd5:    rdata = mc[AW-1:2*DW];
      3'd6:    rdata = res[DW-1:0];
      default: rdata = res[PW-1:DW];
    endcase
  end
endmodule

// File: rtl/mac_periph_sva.sv
module mac_periph_sva #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [2:0]    addr,
  input logic [DW-1:0] wdata,
  input logic          trig,
  input logic          half,
  input logic          half_b,
  input logic          sq,
  input logic          uns,
  input logic [2:0]    op,
  input logic          pend_v,
  input logic [3*DW-1:0] mc,
  input logic [2*DW-1:0] res,
  input logic          ovf
);
  a_r8_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 3'd0 && wdata[5] |=> mc == '0 && res == '0 && !ovf && !half);

  a_r5_hold_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    trig && op[2] && !pend_v |=> $stable(mc));

  a_r6_acc_update_pending: assert property (@(posedge clk) disable iff (!rst_n)
    trig && !op[2] |=> pend_v);

  a_r10_bad_negate_flag: assert property (@(posedge clk) disable iff (!rst_n)
    trig && uns && op[1:0] == 2'b10 |=> ovf);

  a_r4_same_reg_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 3'd1 && !sq && half && !half_b |=> $stable(res));

  a_r3_plain_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    trig && !op[2] && !op[0] && !uns |=> !ovf);
endmodule

bind mac_periph mac_periph_sva #(.DW(DW)) u_sva (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .trig(trig), .half(half), .half_b(half_b), .sq(sq), .uns(uns), .op(op),
  .pend_v(pend_v), .mc(mc), .res(res), .ovf(ovf)
);

// File: tb/mac_periph_tb.sv
`timescale 1ns/100ps
module mac_periph_tb;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0]  addr = '0, rd_addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;

  int n_cmp = 0, n_bad = 0;
  logic [47:0] m_mc = '0;
  bit          m_ov = 1'b0, m_uns = 1'b0, m_sq = 1'b0;
  logic [2:0]  m_op = '0;

  mac_periph u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                    .wdata(wdata), .rd_addr(rd_addr), .rdata(rdata));

  always #2.5 clk = ~clk;

  initial begin
    #100000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic check(input string req, input logic [47:0] got, input logic [47:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    rd_addr = a; #0.2; v = rdata;
  endtask

  task automatic rd_acc(output logic [47:0] v);
    logic [15:0] w0, w1, w2;
    rd(3, w0); rd(4, w1); rd(5, w2);
    v = {w2, w1, w0};
  endtask

  task automatic rd_res(output logic [31:0] v);
    logic [15:0] w0, w1;
    rd(6, w0); rd(7, w1);
    v = {w1, w0};
  endtask

  task automatic set_ctrl(input logic [2:0] op, input bit u, input bit s);
    wr(0, {11'd0, s, u, op});
    m_op = op; m_uns = u; m_sq = s;
  endtask

  task automatic load_acc(input logic [47:0] v);
    wr(3, v[15:0]); wr(4, v[31:16]); wr(5, v[47:32]);
    m_mc = v;
  endtask

  task automatic model(input logic [15:0] a, input logic [15:0] b,
                       output logic [31:0] w, output logic [47:0] mcn);
    longint sa, sb, p, mcs, r, wl;
    bit hold;
    hold = m_op[2];
    sa = m_uns ? longint'(a) : longint'($signed(a));
    sb = m_uns ? longint'(b) : longint'($signed(b));
    p = sa * sb;
    mcs = m_uns ? longint'(m_mc) : longint'($signed(m_mc));
    r = p; wl = p;
    case (m_op[1:0])
      2'b00: begin r = p;  wl = p; if (!hold) m_ov = 1'b0; end
      2'b10: begin r = -p; wl = -p; if (m_uns) m_ov = 1'b1; else if (!hold) m_ov = 1'b0; end
      2'b01: begin r = mcs + p; wl = hold ? mcs + p : mcs + 2 * p; end
      default: begin r = mcs - p; wl = hold ? mcs - p : mcs - 2 * p; end
    endcase
    if (m_op[0] && !hold) begin
      if (m_uns) m_ov = (r < 0) || (r >= 64'sh1_0000_0000_0000);
      else       m_ov = (r > 64'sh7FFF_FFFF_FFFF) || (r < -64'sh8000_0000_0000);
    end
    w = wl[31:0];
    mcn = hold ? m_mc : r[47:0];
  endtask

  task automatic fire(input string req, input logic [15:0] a, input logic [15:0] b, input bit b_first);
    logic [31:0] ew, gw;
    logic [47:0] emc, gmc;
    logic [15:0] c;
    model(a, (m_sq ? a : b), ew, emc);
    if (m_sq) wr(1, a);
    else if (b_first) begin wr(2, b); wr(1, a); end
    else begin wr(1, a); wr(2, b); end
    rd_res(gw);
    check({req, " window"}, 48'(gw), 48'(ew));
    rd(0, c);
    check({req, " flag"}, 48'(c[6]), 48'(m_ov));
    rd_acc(gmc);
    check({req, " R6 acc lag"}, gmc, m_mc);
    @(negedge clk);
    rd_acc(gmc);
    check({req, " acc"}, gmc, emc);
    m_mc = emc;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), v);
      check("R1 reset", 48'(v), 48'd0);
    end
  endtask

  task automatic t_multiply;
    set_ctrl(3'b000, 0, 0);
    fire("R3 signed mul", 16'hFFFD, 16'd5, 0);
    set_ctrl(3'b000, 1, 0);
    fire("R1 unsigned mul", 16'hFFFF, 16'hFFFF, 0);
    set_ctrl(3'b010, 0, 0);
    fire("R3 signed neg", 16'd7, 16'd3, 0);
  endtask

  task automatic t_order;
    logic [31:0] gw;
    set_ctrl(3'b000, 0, 0);
    wr(1, 16'd2); wr(1, 16'd9);
    rd_res(gw);
    check("R4 rewrite no fire", 48'(gw), 48'(32'hFFFF_FFEB));
    wr(2, 16'd3);
    rd_res(gw);
    check("R4 fires with latest A", 48'(gw), 48'd27);
    @(negedge clk);
    m_mc = 48'd27;
    fire("R4 B first", 16'd6, 16'd11, 1);
  endtask

  task automatic t_accum;
    set_ctrl(3'b001, 0, 0);
    load_acc(48'd100);
    fire("R2 accumulate", 16'd4, 16'd5, 0);
    set_ctrl(3'b011, 0, 0);
    fire("R2 subtract", 16'd3, 16'hFFFE, 0);
  endtask

  task automatic t_hold;
    set_ctrl(3'b101, 0, 0);
    fire("R5 hold add", 16'd10, 16'd10, 0);
    set_ctrl(3'b111, 0, 0);
    fire("R5 hold sub", 16'd7, 16'd8, 0);
    set_ctrl(3'b100, 0, 0);
    fire("R5 hold mul", 16'hFFFF, 16'd9, 0);
    set_ctrl(3'b110, 0, 0);
    fire("R5 hold neg", 16'd4, 16'd4, 0);
  endtask

  task automatic t_overflow;
    set_ctrl(3'b001, 0, 0);
    load_acc(48'h7FFF_FFFF_FFFF);
    fire("R9 signed overflow", 16'd1, 16'd1, 0);
    fire("R9 signed no overflow", 16'd1, 16'd1, 0);
    set_ctrl(3'b011, 1, 0);
    load_acc(48'd0);
    fire("R9 unsigned borrow", 16'd1, 16'd1, 0);
    set_ctrl(3'b001, 1, 0);
    load_acc(48'hFFFF_FFFF_FFFF);
    fire("R9 unsigned carry", 16'd2, 16'd1, 0);
  endtask

  task automatic t_bad_negate;
    set_ctrl(3'b000, 0, 0);
    fire("R3 clear flag", 16'd1, 16'd1, 0);
    set_ctrl(3'b010, 1, 0);
    fire("R10 unsigned negate", 16'd5, 16'd6, 0);
  endtask

  task automatic t_square;
    set_ctrl(3'b000, 0, 1);
    fire("R11 square", 16'd12, 16'd0, 0);
    fire("R11 square neg", 16'hFFF0, 16'd0, 0);
  endtask

  task automatic t_back_to_back;
    logic [31:0] ew1, ew2, gw;
    logic [47:0] e1, e2, gmc;
    set_ctrl(3'b001, 0, 1);
    load_acc(48'd0);
    model(16'd2, 16'd2, ew1, e1);
    m_mc = e1;
    model(16'd3, 16'd3, ew2, e2);
    wr(1, 16'd2); wr(1, 16'd3);
    rd_res(gw);
    check("R7 forwarded window", 48'(gw), 48'(ew2));
    @(negedge clk);
    rd_acc(gmc);
    check("R7 forwarded acc", gmc, e2);
    m_mc = e2;
  endtask

  task automatic t_clear;
    logic [15:0] v;
    logic [31:0] gw;
    logic [47:0] gmc;
    set_ctrl(3'b010, 1, 0);
    fire("R10 set before clear", 16'd2, 16'd2, 0);
    wr(0, 16'h0020);
    rd(0, v);
    check("R8 ctrl after clear", 48'(v), 48'd0);
    rd(1, v); check("R8 opa cleared", 48'(v), 48'd0);
    rd(2, v); check("R8 opb cleared", 48'(v), 48'd0);
    rd_acc(gmc); check("R8 acc cleared", gmc, 48'd0);
    rd_res(gw);  check("R8 window cleared", 48'(gw), 48'd0);
    wr(1, 16'd5);
    wr(0, 16'h0020);
    wr(2, 16'd3);
    rd_res(gw);
    check("R8 count reset", 48'(gw), 48'd0);
    wr(1, 16'd4);
    rd_res(gw);
    check("R8 fires after clear", 48'(gw), 48'd12);
    @(negedge clk);
    m_mc = 48'd12; m_op = 3'b000; m_uns = 1'b0; m_sq = 1'b0; m_ov = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_multiply;
    t_order;
    t_accum;
    t_hold;
    t_overflow;
    t_bad_negate;
    t_square;
    t_back_to_back;
    t_clear;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule